// File: doc/BRIEF.md
# Write-Once Page Load Buffer

This block is the staging store that sits in front of a flash page programmer. Software fills it one 16-bit word at a time. Each load command supplies a pointer, whose word-select bits pick the location, and a data word. A location accepts data only once per fill cycle. A per-location flag records that it is occupied, and any later load to that location is dropped until the buffer is wiped.

Several events wipe the buffer in a single clock:
- a synchronous reset;
- the flash path reporting that a page write has finished;
- a section re-enable command;
- an EEPROM write that begins while at least one word is loaded.

A page write command is checked before it is handed on. It is issued only when the word-select bits of the pointer are all zero. Otherwise it is refused with an error pulse. A registered read port lets the programmer fetch any word of the page while it burns the flash.

With default parameters the pointer layout is as follows:
- bit 0 is ignored;
- bits 5:1 select one of 32 words;
- bits 12:6 carry the page number;
- bits 15:13 are ignored.

Top module: `pgbuf_top`

## Requirements
- R1: A command with `cmd_valid` high and `cmd_op` = 1 (load) stores `wdata` at word index `z_ptr[5:1]`, and `z_ptr[0]` and `z_ptr[15:13]` have no effect on it. `rd_data` returns the word at `rd_idx` one clock after `rd_idx` is presented.
- R2: A load to a location whose flag is already set leaves the stored word unchanged.
- R3: Bit i of `loaded_mask` is 1 exactly when location i has accepted a load since the last wipe, and the bit is visible one clock after that load.
- R4: A `pg_wr_done` pulse wipes the buffer on that clock edge: every word reads 16'hFFFF and `loaded_mask` is zero.
- R5: A command with `cmd_op` = 3 (re-enable) wipes the buffer in the same way.
- R6: Synchronous active-high `rst` wipes the buffer and drives `wr_start` and `cmd_err` low and `rd_data` to 16'hFFFF.
- R7: `ee_wr_start` wipes the buffer when any bit of `loaded_mask` is set, and has no effect when the mask is zero.
- R8: When a wipe and a load fall in the same clock, the wipe wins and the load is dropped.
- R9: A command with `cmd_op` = 2 (page write) and `z_ptr[5:1]` = 0 produces a one-clock `wr_start` pulse with `wr_page` = `z_ptr[12:6]` on the next clock, and leaves the buffer contents unchanged.
- R10: A page write command with nonzero `z_ptr[5:1]` produces a one-clock `cmd_err` pulse and no `wr_start`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command strobe for this clock |
| cmd_op | input | 2 | 0 none, 1 load, 2 page write, 3 re-enable |
| z_ptr | input | 16 | Pointer: word index in bits 5:1, page in bits 12:6 |
| wdata | input | 16 | Word to load |
| ee_wr_start | input | 1 | An EEPROM write begins this clock |
| pg_wr_done | input | 1 | Flash path finished a page write |
| rd_idx | input | 5 | Word index for the read port |
| rd_data | output | 16 | Registered word at `rd_idx` |
| loaded_mask | output | 32 | Per-location occupied flags |
| wr_start | output | 1 | One-clock pulse issuing a page write |
| wr_page | output | 7 | Page number of the last issued write |
| cmd_err | output | 1 | One-clock pulse on a refused page write |

## Verification
The two functions that can meet in one clock are a word load and a wipe. The wipe can come from an EEPROM write start or from a page-write completion. The bench provokes both collisions by driving the load command together with `ee_wr_start` on a partly filled buffer, and together with `pg_wr_done`. It then reads back every location to confirm that the wipe won and that the colliding word never arrived. The opposite case is also covered: an EEPROM write start arriving on an empty buffer together with a load must keep that load. Each outcome is judged against a model of all flags and words held in the bench.

// File: rtl/pgbuf_pkg.sv
package pgbuf_pkg;
  typedef enum logic [1:0] {
    OP_NONE = 2'd0,
    OP_LOAD = 2'd1,
    OP_PGWR = 2'd2,
    OP_REEN = 2'd3
  } pb_op_e;
endpackage

// File: rtl/pgbuf_dec.sv
module pgbuf_dec
  import pgbuf_pkg::*;
#(
  parameter int IDX_W  = 5,
  parameter int PAGE_W = 7,
  parameter int Z_W    = 16
) (
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [Z_W-1:0]    z_ptr,
  input  logic              ee_wr_start,
  input  logic              pg_wr_done,
  input  logic              any_loaded,
  output logic              erase,
  output logic              load_req,
  output logic [IDX_W-1:0]  load_idx,
  output logic              pgwr_ok,
  output logic              pgwr_bad,
  output logic [PAGE_W-1:0] pgwr_page
);
  localparam int PG_LO = IDX_W + 1;
  localparam int PG_HI = IDX_W + PAGE_W;

  pb_op_e op;
  logic   word_zero;
  logic   unused_zbits;

  assign op        = pb_op_e'(cmd_op);
  assign load_idx  = z_ptr[IDX_W:1];
  assign pgwr_page = z_ptr[PG_HI:PG_LO];
  assign word_zero = (load_idx == '0);

  // Bit 0 and the bits above the page field play no part in any command.
  assign unused_zbits = ^{z_ptr[0], z_ptr[Z_W-1:PG_HI+1]};

  // Any one of the wipe sources clears the whole store.
  assign erase = pg_wr_done
               | (cmd_valid && op == OP_REEN)
               | (ee_wr_start && any_loaded);

  // A wipe in the same clock takes precedence over a load.
  assign load_req = cmd_valid && op == OP_LOAD && !erase;

  assign pgwr_ok  = cmd_valid && op == OP_PGWR &&  word_zero;
  assign pgwr_bad = cmd_valid && op == OP_PGWR && !word_zero;
endmodule

// File: rtl/pgbuf_store.sv
module pgbuf_store #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 16,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              erase,
  input  logic              load_req,
  input  logic [IDX_W-1:0]  load_idx,
  input  logic [DATA_W-1:0] load_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DEPTH-1:0]  flags
);
  logic [DEPTH-1:0][DATA_W-1:0] words_w;

  // Per-location cells: each one clears on a wipe and accepts a single load.
  for (genvar i = 0; i < DEPTH; i++) begin : g_cell
    logic [DATA_W-1:0] cell_q;
    logic              full_q;

    always_ff @(posedge clk) begin
      if (rst || erase) begin
        cell_q <= '1;
        full_q <= 1'b0;
      end else if (load_req && load_idx == IDX_W'(i) && !full_q) begin
        cell_q <= load_data;
        full_q <= 1'b1;
      end
    end

    assign words_w[i] = cell_q;
    assign flags[i]   = full_q;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '1;
    else     rd_data <= words_w[rd_idx];
  end
endmodule

// File: rtl/pgbuf_issue.sv
module pgbuf_issue #(
  parameter int PAGE_W = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pgwr_ok,
  input  logic              pgwr_bad,
  input  logic [PAGE_W-1:0] pgwr_page,
  output logic              wr_start,
  output logic [PAGE_W-1:0] wr_page,
  output logic              cmd_err
);
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_start <= 1'b0;
      cmd_err  <= 1'b0;
      wr_page  <= '0;
    end else begin
      wr_start <= pgwr_ok;
      cmd_err  <= pgwr_bad;
      if (pgwr_ok) wr_page <= pgwr_page;
    end
  end
endmodule

// File: rtl/pgbuf_top.sv
module pgbuf_top #(
  parameter int IDX_W  = 5,
  parameter int DATA_W = 16,
  parameter int PAGE_W = 7,
  parameter int Z_W    = 16,
  localparam int DEPTH = 1 << IDX_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [Z_W-1:0]    z_ptr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              ee_wr_start,
  input  logic              pg_wr_done,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic [DEPTH-1:0]  loaded_mask,
  output logic              wr_start,
  output logic [PAGE_W-1:0] wr_page,
  output logic              cmd_err
);
  logic              erase;
  logic              load_req;
  logic [IDX_W-1:0]  load_idx;
  logic              pgwr_ok;
  logic              pgwr_bad;
  logic [PAGE_W-1:0] pgwr_page;
  logic [DEPTH-1:0]  flags;

  pgbuf_dec #(.IDX_W(IDX_W), .PAGE_W(PAGE_W), .Z_W(Z_W)) u_dec (
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .z_ptr      (z_ptr),
    .ee_wr_start(ee_wr_start),
    .pg_wr_done (pg_wr_done),
    .any_loaded (|flags),
    .erase      (erase),
    .load_req   (load_req),
    .load_idx   (load_idx),
    .pgwr_ok    (pgwr_ok),
    .pgwr_bad   (pgwr_bad),
    .pgwr_page  (pgwr_page)
  );

  pgbuf_store #(.IDX_W(IDX_W), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rst      (rst),
    .erase    (erase),
    .load_req (load_req),
    .load_idx (load_idx),
    .load_data(wdata),
    .rd_idx   (rd_idx),
    .rd_data  (rd_data),
    .flags    (flags)
  );

  pgbuf_issue #(.PAGE_W(PAGE_W)) u_issue (
    .clk      (clk),
    .rst      (rst),
    .pgwr_ok  (pgwr_ok),
    .pgwr_bad (pgwr_bad),
    .pgwr_page(pgwr_page),
    .wr_start (wr_start),
    .wr_page  (wr_page),
    .cmd_err  (cmd_err)
  );

  assign loaded_mask = flags;
endmodule

// File: rtl/pgbuf_chk.sv
module pgbuf_chk #(
  parameter int IDX_W  = 5,
  parameter int PAGE_W = 7,
  parameter int Z_W    = 16,
  localparam int DEPTH = 1 << IDX_W
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_valid,
  input logic [1:0]        cmd_op,
  input logic [Z_W-1:0]    z_ptr,
  input logic              ee_wr_start,
  input logic              pg_wr_done,
  input logic [DEPTH-1:0]  loaded_mask,
  input logic              wr_start,
  input logic [PAGE_W-1:0] wr_page,
  input logic              cmd_err
);
  logic armed;
  logic rst_q;
  logic unused_chk;

  assign unused_chk = ^{z_ptr[0], z_ptr[Z_W-1:IDX_W+PAGE_W+1]};

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) armed <= 1'b0;
    else     armed <= 1'b1;
  end

  // R6
  always_ff @(posedge clk) begin
    if (rst_q) begin
      reset_state_chk: assert (loaded_mask == '0 && !wr_start && !cmd_err);
    end
  end

  // R3
  load_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd1 && !pg_wr_done && !ee_wr_start)
      |=> loaded_mask[$past(z_ptr[IDX_W:1])]);

  // R2
  flags_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && !pg_wr_done && !ee_wr_start && !(cmd_valid && cmd_op == 2'd3))
      |=> ((loaded_mask & $past(loaded_mask)) == $past(loaded_mask)));

  // R4
  done_wipes_chk: assert property (@(posedge clk) disable iff (rst)
    pg_wr_done |=> loaded_mask == '0);

  // R5
  reenable_wipes_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd3) |=> loaded_mask == '0);

  // R7
  ee_wipes_chk: assert property (@(posedge clk) disable iff (rst)
    (ee_wr_start && loaded_mask != '0) |=> loaded_mask == '0);

  // R9
  pgwr_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2 && z_ptr[IDX_W:1] == '0)
      |=> (wr_start && !cmd_err && wr_page == $past(z_ptr[IDX_W+PAGE_W:IDX_W+1])));

  // R10
  pgwr_refuse_chk: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_op == 2'd2 && z_ptr[IDX_W:1] != '0) |=> (cmd_err && !wr_start));

  // R10
  pulses_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
    !(wr_start && cmd_err));
endmodule

bind pgbuf_top pgbuf_chk #(.IDX_W(IDX_W), .PAGE_W(PAGE_W), .Z_W(Z_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cmd_valid  (cmd_valid),
  .cmd_op     (cmd_op),
  .z_ptr      (z_ptr),
  .ee_wr_start(ee_wr_start),
  .pg_wr_done (pg_wr_done),
  .loaded_mask(loaded_mask),
  .wr_start   (wr_start),
  .wr_page    (wr_page),
  .cmd_err    (cmd_err)
);

// File: tb/pgbuf_top_test.sv
module pgbuf_top_test;
  localparam int N = 32;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [1:0]  cmd_op = 2'd0;
  logic [15:0] z_ptr = 16'd0;
  logic [15:0] wdata = 16'd0;
  logic        ee_wr_start = 1'b0;
  logic        pg_wr_done = 1'b0;
  logic [4:0]  rd_idx = 5'd0;
  logic [15:0] rd_data;
  logic [N-1:0] loaded_mask;
  logic        wr_start;
  logic [6:0]  wr_page;
  logic        cmd_err;

  int vectors = 0;
  int fails = 0;
  bit done = 1'b0;

  logic [15:0]  exp_mem [N];
  logic [N-1:0] exp_flag;

  always #2 clk = ~clk;

  pgbuf_top uut (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .z_ptr(z_ptr),
    .wdata(wdata), .ee_wr_start(ee_wr_start), .pg_wr_done(pg_wr_done),
    .rd_idx(rd_idx), .rd_data(rd_data), .loaded_mask(loaded_mask),
    .wr_start(wr_start), .wr_page(wr_page), .cmd_err(cmd_err)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic model_wipe();
    for (int i = 0; i < N; i++) exp_mem[i] = 16'hFFFF;
    exp_flag = '0;
  endtask

  function automatic logic [15:0] pat(input int i, input logic [15:0] k);
    return 16'(i * 16'h0421) ^ k;
  endfunction

  function automatic logic [15:0] mkz(input int page, input int idx, input bit junk);
    return {junk ? 3'b101 : 3'b000, 7'(page), 5'(idx), junk};
  endfunction

  // Drive one clock of stimulus and update the bench model from the requirements.
  task automatic step(input bit v, input logic [1:0] op, input logic [15:0] z,
                      input logic [15:0] d, input bit ee, input bit wd);
    bit wipe;
    int idx;
    cmd_valid = v; cmd_op = op; z_ptr = z; wdata = d;
    ee_wr_start = ee; pg_wr_done = wd;
    idx = int'(z[5:1]);
    wipe = wd || (v && op == 2'd3) || (ee && exp_flag != '0);
    tick();
    if (wipe) model_wipe();
    else if (v && op == 2'd1 && !exp_flag[idx]) begin
      exp_mem[idx] = d;
      exp_flag[idx] = 1'b1;
    end
    cmd_valid = 1'b0; cmd_op = 2'd0; ee_wr_start = 1'b0; pg_wr_done = 1'b0;
  endtask

  task automatic check_all(input string tag);
    chk(loaded_mask, exp_flag, {tag, " mask R3"});
    for (int i = 0; i < N; i++) begin
      rd_idx = 5'(i);
      tick();
      chk(32'(rd_data), 32'(exp_mem[i]), {tag, " word R1"});
    end
  endtask

  task automatic do_reset();
    rst = 1'b1;
    tick();
    tick();
    rst = 1'b0;
    model_wipe();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    model_wipe();
    @(negedge clk);
    do_reset();
    // R6: state straight out of reset
    chk(loaded_mask, '0, "R6 mask");
    chk(32'(wr_start), 0, "R6 wr_start");
    chk(32'(cmd_err), 0, "R6 cmd_err");
    chk(32'(rd_data), 32'hFFFF, "R6 rd_data");
    check_all("R6 empty");

    // R1 R3: fill every location, with the ignored pointer bits set
    for (int i = 0; i < N; i++) begin
      step(1, 2'd1, mkz(i % 128, i, 1), pat(i, 16'hA55A), 0, 0);
      chk(32'(loaded_mask[i]), 1, "R3 flag after load");
    end
    check_all("R1 fill");

    // R2: a second pass with different data is ignored
    for (int i = 0; i < N; i++) step(1, 2'd1, mkz(0, i, 0), ~pat(i, 16'hA55A), 0, 0);
    check_all("R2 rewrite");

    // R9: an accepted page write issues and leaves the contents alone
    step(1, 2'd2, mkz(7'h2B, 0, 1), 16'h0, 0, 0);
    chk(32'(wr_start), 1, "R9 wr_start");
    chk(32'(wr_page), 32'h2B, "R9 wr_page");
    chk(32'(cmd_err), 0, "R9 cmd_err");
    step(0, 2'd0, 16'h0, 16'h0, 0, 0);
    chk(32'(wr_start), 0, "R9 pulse width");
    check_all("R9 contents");

    // R10: every nonzero word index refuses the page write
    for (int w = 1; w < N; w++) begin
      step(1, 2'd2, mkz(w, w, 0), 16'h0, 0, 0);
      chk(32'(cmd_err), 1, "R10 cmd_err");
      chk(32'(wr_start), 0, "R10 wr_start");
      chk(32'(wr_page), 32'h2B, "R10 wr_page held");
    end
    step(0, 2'd0, 16'h0, 16'h0, 0, 0);
    chk(32'(cmd_err), 0, "R10 pulse width");

    // R4: completion of the page write wipes
    step(0, 2'd0, 16'h0, 16'h0, 0, 1);
    check_all("R4 done");

    // R5: re-enable wipes a half-filled buffer
    for (int i = 0; i < N; i += 2) step(1, 2'd1, mkz(3, i, 0), pat(i, 16'h3C3C), 0, 0);
    check_all("R5 before");
    step(1, 2'd3, mkz(3, 5, 0), 16'h0, 0, 0);
    check_all("R5 after");

    // R7: EEPROM start on an empty buffer keeps a load in the same clock
    step(1, 2'd1, mkz(0, 3, 0), 16'h1234, 1, 0);
    check_all("R7 empty keeps");

    // R7 R8: EEPROM start while loading wins over a colliding load
    step(1, 2'd1, mkz(0, 8, 0), 16'h0808, 0, 0);
    step(1, 2'd1, mkz(0, 9, 0), 16'h0909, 1, 0);
    check_all("R8 ee collision");

    // R8: completion pulse wins over a colliding load
    step(1, 2'd1, mkz(0, 4, 0), 16'h4444, 0, 0);
    step(1, 2'd1, mkz(0, 6, 0), 16'h6666, 0, 1);
    check_all("R8 done collision");

    // R6: reset in the middle of loading
    for (int i = 0; i < 5; i++) step(1, 2'd1, mkz(1, i + 20, 0), pat(i, 16'h0F0F), 0, 0);
    check_all("R6 before");
    do_reset();
    check_all("R6 mid-load");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule